// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Next-PC Select

This block sits in the fetch stage. Every cycle it looks up the current fetch address in a small direct-mapped table of branch targets and picks the next fetch address. The answer is combinational, so it is ready in the same cycle as the lookup. A row is chosen by the low word-address bits of the PC. The rest of the PC is kept in the row as a tag. A row holds the destination of the taken branch that last used it, not the branch's own address.

A separate direction predictor supplies a taken bit. A hit redirects fetch only when that bit is set. In every other case the next address is the sequential PC+4. The resolve stage installs entries through an update port: a branch that misses on its first run is learned and hits from then on. A branch that maps to an occupied row evicts the older entry outright. A global invalidate clears every row, for example after code has been rewritten.

Top module: `btb_next_pc`

## Requirements
- R1: After reset no lookup hits, `hit_target` reads zero and `next_pc` equals `lookup_pc + 4`.
- R2: On a miss `hit` is 0 and `next_pc` equals `lookup_pc + 4`. The direction input has no effect on a miss.
- R3: The row index is `pc[IDX_W+1:2]`. The tag is all other PC bits. A hit needs a valid row whose stored tag equals the lookup PC's tag. Any other address that maps to the same row misses.
- R4: On a hit with `pred_taken` = 1, `next_pc` equals the stored target in the same cycle as the lookup.
- R5: On a hit with `pred_taken` = 0, `hit` stays 1, `hit_target` still shows the stored target, and `next_pc` equals `lookup_pc + 4`.
- R6: An update (`upd_en` = 1) writes `upd_pc`'s tag and `upd_target` into its row at the next rising clock edge. From then on, a lookup of `upd_pc` hits with that target.
- R7: An update to a row that already holds an entry replaces it. The earlier branch's PC then misses.
- R8: A lookup and an update to the same row in one cycle return the row's old contents. The new contents are seen from the next cycle.
- R9: `inval` = 1 clears every row at the next edge. When `inval` and `upd_en` are both set in a cycle, the invalidate wins and the update is dropped.
- R10: `hit_target` reads zero whenever `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears all valid bits |
| lookup_pc | input | ADDR_W | Current fetch address |
| pred_taken | input | 1 | Direction bit from the external predictor |
| hit | output | 1 | Valid row with a matching tag |
| hit_target | output | ADDR_W | Stored target on a hit, zero otherwise |
| next_pc | output | ADDR_W | Chosen next fetch address |
| upd_en | input | 1 | Install an entry from the resolve stage |
| upd_pc | input | ADDR_W | Address of the resolved taken branch |
| upd_target | input | ADDR_W | Resolved target of that branch |
| inval | input | 1 | Clear every row |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a lookup and a write to the same row. The bench presents the lookup PC while the update to that PC is asserted. Before the edge it expects the old contents (a miss, or the earlier target), and after the edge it expects the new target. The second pair is invalidate and update. The bench raises both in one cycle and then expects a miss on the address that was being written, as well as on an address installed earlier.

// File: rtl/btb_next_pc.sv
module btb_next_pc #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lookup_pc,
  input  logic              pred_taken,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_target,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              inval
);
  localparam int ROWS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ROWS-1:0]   row_valid;
  logic [TAG_W-1:0]  row_tag [ROWS];
  logic [ADDR_W-1:0] row_tgt [ROWS];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic [ADDR_W-1:0] seq_pc;

  assign rd_idx = lookup_pc[IDX_W+1:2];
  assign rd_tag = {lookup_pc[ADDR_W-1:IDX_W+2], lookup_pc[1:0]};
  assign wr_idx = upd_pc[IDX_W+1:2];
  assign wr_tag = {upd_pc[ADDR_W-1:IDX_W+2], upd_pc[1:0]};
  assign seq_pc = lookup_pc + ADDR_W'(4);

  assign hit        = row_valid[rd_idx] && (row_tag[rd_idx] == rd_tag);
  assign hit_target = hit ? row_tgt[rd_idx] : '0;
  assign next_pc    = (hit && pred_taken) ? hit_target : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n || inval)
      row_valid <= '0;
    else if (upd_en)
      row_valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_en && !inval) begin
      row_tag[wr_idx] <= wr_tag;
      row_tgt[wr_idx] <= upd_target;
    end
  end

  // Miss falls through to the sequential address (R2)
  assert_miss_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (next_pc == lookup_pc + ADDR_W'(4) && hit_target == '0));

  assert_taken_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pred_taken) |-> next_pc == hit_target);

  assert_not_taken_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pred_taken) |-> next_pc == lookup_pc + ADDR_W'(4));

  assert_install_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !inval) |=> (lookup_pc != $past(upd_pc) ||
                            (hit && hit_target == $past(upd_target))));

  assert_inval_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !hit);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> !hit);
endmodule

// File: tb/sim_btb_next_pc.sv
module sim_btb_next_pc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        pred_taken = 1'b0;
  logic        hit;
  logic [31:0] hit_target, next_pc;
  logic        upd_en = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0;
  logic        inval = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btb_next_pc #(.ADDR_W(32), .IDX_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred_taken),
    .hit(hit), .hit_target(hit_target), .next_pc(next_pc),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target), .inval(inval));

  localparam logic [31:0] PC_A = 32'h0000_100C; // row 3
  localparam logic [31:0] PC_B = 32'h0000_200C; // row 3, other tag
  localparam logic [31:0] PC_C = 32'h0000_1014; // row 5
  localparam logic [31:0] T_A  = 32'h0000_4000;
  localparam logic [31:0] T_B  = 32'h0000_8000;
  localparam logic [31:0] T_C  = 32'h0000_C000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(string req, logic [31:0] pc, logic tk, logic eh,
                      logic [31:0] et, logic [31:0] en);
    @(negedge clk);
    lookup_pc = pc; pred_taken = tk;
    #1;
    check({req, " hit"}, {31'b0, hit}, {31'b0, eh});
    check({req, " target"}, hit_target, et);
    check({req, " next"}, next_pc, en);
  endtask

  task automatic write(logic [31:0] pc, logic [31:0] t);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_target = t;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic t_reset_r1;
    look("R1 reset", PC_A, 1'b1, 1'b0, 32'h0, PC_A + 4);
    look("R1 reset row5", PC_C, 1'b0, 1'b0, 32'h0, PC_C + 4);
  endtask

  task automatic t_install_r6;
    write(PC_A, T_A);
    look("R6 installed", PC_A, 1'b1, 1'b1, T_A, T_A);
    look("R4 taken redirect", PC_A, 1'b1, 1'b1, T_A, T_A);
    look("R5 not taken", PC_A, 1'b0, 1'b1, T_A, PC_A + 4);
  endtask

  task automatic t_alias_r3_r7;
    look("R3 alias miss", PC_B, 1'b1, 1'b0, 32'h0, PC_B + 4);
    look("R2 miss other row", PC_C, 1'b1, 1'b0, 32'h0, PC_C + 4);
    look("R3 low bit tag miss", PC_A + 1, 1'b1, 1'b0, 32'h0, PC_A + 5);
    write(PC_B, T_B);
    look("R7 new owner hits", PC_B, 1'b1, 1'b1, T_B, T_B);
    look("R7 evicted misses", PC_A, 1'b1, 1'b0, 32'h0, PC_A + 4);
    look("R10 miss target zero", PC_A, 1'b0, 1'b0, 32'h0, PC_A + 4);
  endtask

  task automatic t_same_cycle_r8;
    @(negedge clk);
    lookup_pc = PC_A; pred_taken = 1'b1;
    upd_en = 1'b1; upd_pc = PC_A; upd_target = T_C;
    #1;
    check("R8 old contents hit", {31'b0, hit}, 32'h0);
    check("R8 old contents next", next_pc, PC_A + 4);
    @(negedge clk);
    upd_en = 1'b0;
    #1;
    check("R8 new contents hit", {31'b0, hit}, 32'h1);
    check("R8 new contents next", next_pc, T_C);
    write(PC_C, T_A);
    @(negedge clk);
    lookup_pc = PC_C; upd_en = 1'b1; upd_pc = PC_C; upd_target = T_B;
    #1;
    check("R8 old target kept", hit_target, T_A);
    @(negedge clk);
    upd_en = 1'b0;
    #1;
    check("R8 target replaced", hit_target, T_B);
  endtask

  task automatic t_inval_r9;
    @(negedge clk);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    look("R9 cleared row3", PC_A, 1'b1, 1'b0, 32'h0, PC_A + 4);
    look("R9 cleared row5", PC_C, 1'b1, 1'b0, 32'h0, PC_C + 4);
    write(PC_A, T_A);
    @(negedge clk);
    inval = 1'b1; upd_en = 1'b1; upd_pc = PC_C; upd_target = T_C;
    @(negedge clk);
    inval = 1'b0; upd_en = 1'b0;
    look("R9 inval beats update", PC_C, 1'b1, 1'b0, 32'h0, PC_C + 4);
    look("R9 earlier entry gone", PC_A, 1'b1, 1'b0, 32'h0, PC_A + 4);
  endtask

  task automatic t_reset_again_r1;
    write(PC_A, T_A);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look("R1 reset clears entry", PC_A, 1'b1, 1'b0, 32'h0, PC_A + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_install_r6();
    t_alias_r3_r7();
    t_same_cycle_r8();
    t_inval_r9();
    t_reset_again_r1();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule